// File: doc/BRIEF.md
# DMA Channel Interrupt Status Collector

This block gathers per-channel event pulses from a sixteen-channel DMA engine and turns them into software-visible state plus one interrupt line. Every channel reports three kinds of event: transfer done, and two distinct error classes (class A and class B). For each class the block keeps a sticky raw latch, an enable mask and a masked view. A summary word flags each channel that has any enabled event pending, and the interrupt output is the OR of that summary.

Software programs the three mask words, reads the summary to find which channels need service (lowest bit first), and clears a raw bit by writing 1 to it. A dedicated stop-clear word clears one channel's raw bit in all three classes with a single write. A busy word returns the live per-channel running flags supplied by the engine. All register words are NCH bits wide, and bit i always belongs to channel i. Reads return data one clock after the address is presented.

Top module: `dmairq_agg`

## Requirements
- R1: After synchronous reset every raw latch, every mask, the summary word and `irq` are zero.
- R2: A one-cycle pulse on bit i of an event input sets raw bit i of that class at the next clock edge, and it stays set until cleared. The raw words are read at address 0x8 (done), 0x9 (error A) and 0xA (error B).
- R3: The masked word of each class equals its raw word ANDed with its mask word. The masked words are read at address 0x1 (done), 0x2 (error A) and 0x3 (error B).
- R4: A mask bit of 1 enables the event and 0 disables it. A write to address 0x4 (done), 0x5 (error A) or 0x6 (error B) loads the whole mask word, and the word reads back at the same address.
- R5: A write to a raw address clears every raw bit whose write-data bit is 1 and leaves every bit whose write-data bit is 0 unchanged.
- R6: An event pulse on the same clock edge as a clear of the same bit leaves that bit set.
- R7: The summary word at address 0x0 has bit i set exactly when channel i has a set bit in any of the three masked words.
- R8: `irq` is a registered level. It is high one clock after the summary word is non-zero and low one clock after it is zero.
- R9: A write to address 0xC clears, for every channel whose write-data bit is 1, the raw bit in all three classes in the same clock edge.
- R10: A read of address 0xB returns the `chan_busy` input as it was sampled at the read edge.
- R11: A read of address 0xC or of any unmapped address (0x7, 0xD to 0xF) returns zero. A write to a read-only address changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_done | input | NCH | Per-channel transfer-done pulses |
| evt_erra | input | NCH | Per-channel error class A pulses |
| evt_errb | input | NCH | Per-channel error class B pulses |
| chan_busy | input | NCH | Per-channel running flags from the engine |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word address |
| wdata | input | NCH | Register write data |
| rdata | output | NCH | Registered read data for the previous address |
| irq | output | 1 | Level interrupt, OR of the summary word |

## Verification
The assertions assume that each event input is a single-cycle pulse per occurrence. They also assume that a register write lasts one cycle with a stable address and data, so that every clear or mask load maps to exactly one edge. The stimulus drives events, writes and the busy word on the falling edge and holds them for one full cycle. Random event vectors are mixed with random writes to every writable address and to a read-only one. Directed cases force an event to collide with a write-1 clear and with a stop-clear on the same bit.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int ADDR_W = 4;
  localparam int NCLS   = 3;

  localparam logic [ADDR_W-1:0] A_SUMMARY = 4'h0;
  localparam logic [ADDR_W-1:0] A_MSKD0   = 4'h1;
  localparam logic [ADDR_W-1:0] A_MASK0   = 4'h4;
  localparam logic [ADDR_W-1:0] A_RAW0    = 4'h8;
  localparam logic [ADDR_W-1:0] A_BUSY    = 4'hB;
  localparam logic [ADDR_W-1:0] A_STOP    = 4'hC;
endpackage

// File: rtl/dmairq_class.sv
module dmairq_class #(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] evt,
  input  logic [NCH-1:0] clr,
  input  logic           mask_we,
  input  logic [NCH-1:0] mask_d,
  output logic [NCH-1:0] raw,
  output logic [NCH-1:0] mask,
  output logic [NCH-1:0] masked
);
  always_ff @(posedge clk) begin
    if (rst) begin
      raw  <= '0;
      mask <= '0;
    end else begin
      raw <= (raw & ~clr) | evt;
      if (mask_we) mask <= mask_d;
    end
  end

  assign masked = raw & mask;

  p_evt_sets_r2: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((raw & $past(evt)) == $past(evt)));

  p_evt_beats_clr_r6: assert property (@(posedge clk) disable iff (rst)
    (|(evt & clr)) |=> ((raw & $past(evt & clr)) == $past(evt & clr)));

  p_w1c_clears_r5: assert property (@(posedge clk) disable iff (rst)
    (|(clr & ~evt)) |=> ((raw & $past(clr & ~evt)) == '0));

  p_zero_keeps_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((raw & $past(raw & ~clr)) == $past(raw & ~clr)));

  p_mask_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !mask_we |=> $stable(mask));
endmodule

// File: rtl/dmairq_rdmux.sv
module dmairq_rdmux
  import dmairq_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [NCH-1:0]            summary,
  input  logic [NCLS-1:0][NCH-1:0]  masked,
  input  logic [NCLS-1:0][NCH-1:0]  mask,
  input  logic [NCLS-1:0][NCH-1:0]  raw,
  input  logic [NCH-1:0]            busy,
  output logic [NCH-1:0]            rdata
);
  logic [NCH-1:0] sel;

  always_comb begin
    sel = '0;
    if (addr == A_SUMMARY) sel = summary;
    if (addr == A_BUSY)    sel = busy;
    for (int c = 0; c < NCLS; c++) begin
      if (addr == A_MSKD0 + ADDR_W'(c)) sel = masked[c];
      if (addr == A_MASK0 + ADDR_W'(c)) sel = mask[c];
      if (addr == A_RAW0  + ADDR_W'(c)) sel = raw[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= sel;
  end

  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (addr == A_STOP || addr == 4'h7 || addr > A_STOP) |=> (rdata == '0));

  p_busy_read_r10: assert property (@(posedge clk) disable iff (rst)
    (addr == A_BUSY) |=> (rdata == $past(busy)));
endmodule

// File: rtl/dmairq_agg.sv
module dmairq_agg
  import dmairq_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    evt_done,
  input  logic [NCH-1:0]    evt_erra,
  input  logic [NCH-1:0]    evt_errb,
  input  logic [NCH-1:0]    chan_busy,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NCH-1:0]    wdata,
  output logic [NCH-1:0]    rdata,
  output logic              irq
);
  logic [NCLS-1:0][NCH-1:0] evt_all, clr_all, raw_all, mask_all, mskd_all;
  logic [NCLS-1:0]          mask_we;
  logic [NCH-1:0]           stop_clr, summary;

  assign evt_all[0] = evt_done;
  assign evt_all[1] = evt_erra;
  assign evt_all[2] = evt_errb;

  assign stop_clr = (wr_en && addr == A_STOP) ? wdata : '0;

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    assign clr_all[c] = stop_clr |
                        ((wr_en && addr == A_RAW0 + ADDR_W'(c)) ? wdata : '0);
    assign mask_we[c] = wr_en && (addr == A_MASK0 + ADDR_W'(c));

    dmairq_class #(.NCH(NCH)) u_cls (
      .clk     (clk),
      .rst     (rst),
      .evt     (evt_all[c]),
      .clr     (clr_all[c]),
      .mask_we (mask_we[c]),
      .mask_d  (wdata),
      .raw     (raw_all[c]),
      .mask    (mask_all[c]),
      .masked  (mskd_all[c])
    );
  end

  always_comb begin
    summary = '0;
    for (int c = 0; c < NCLS; c++) summary = summary | mskd_all[c];
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |summary;
  end

  dmairq_rdmux #(.NCH(NCH)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .addr    (addr),
    .summary (summary),
    .masked  (mskd_all),
    .mask    (mask_all),
    .raw     (raw_all),
    .busy    (chan_busy),
    .rdata   (rdata)
  );

  p_irq_set_r8: assert property (@(posedge clk) disable iff (rst)
    (|summary) |=> irq);

  p_irq_clr_r8: assert property (@(posedge clk) disable iff (rst)
    (summary == '0) |=> !irq);

  p_stop_all_r9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == A_STOP) |=>
      (((raw_all[0] | raw_all[1] | raw_all[2]) &
        $past(wdata & ~(evt_done | evt_erra | evt_errb))) == '0));
endmodule

// File: tb/sim_dmairq_agg.sv
module sim_dmairq_agg;
  localparam int N = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] evt_done = '0, evt_erra = '0, evt_errb = '0, chan_busy = '0;
  logic         wr_en = 1'b0;
  logic [3:0]   addr = '0;
  logic [N-1:0] wdata = '0;
  logic [N-1:0] rdata;
  logic         irq;

  int checks = 0;
  int fails  = 0;

  logic [N-1:0] m_raw  [3];
  logic [N-1:0] m_mask [3];

  always #2 clk = ~clk;

  dmairq_agg #(.NCH(N)) u0 (
    .clk(clk), .rst(rst), .evt_done(evt_done), .evt_erra(evt_erra),
    .evt_errb(evt_errb), .chan_busy(chan_busy), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic logic [N-1:0] m_summary();
    return (m_raw[0] & m_mask[0]) | (m_raw[1] & m_mask[1]) | (m_raw[2] & m_mask[2]);
  endfunction

  function automatic logic [N-1:0] exp_read(input logic [3:0] a);
    case (a)
      4'h0: return m_summary();
      4'h1, 4'h2, 4'h3: return m_raw[a-1] & m_mask[a-1];
      4'h4, 4'h5, 4'h6: return m_mask[a-4];
      4'h8, 4'h9, 4'hA: return m_raw[a-8];
      4'hB: return chan_busy;
      default: return '0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] a);
    case (a)
      4'h0: return "R7 summary";
      4'h1, 4'h2, 4'h3: return "R3 masked";
      4'h4, 4'h5, 4'h6: return "R4 mask";
      4'h8, 4'h9, 4'hA: return "R2/R5 raw";
      4'hB: return "R10 busy";
      default: return "R11 unmapped";
    endcase
  endfunction

  // one cycle of events plus an optional write; model updated afterwards
  task automatic step(input logic [N-1:0] ed, input logic [N-1:0] ea,
                      input logic [N-1:0] eb, input logic we,
                      input logic [3:0] a, input logic [N-1:0] d);
    logic [N-1:0] ev [3];
    ev[0] = ed; ev[1] = ea; ev[2] = eb;
    evt_done = ed; evt_erra = ea; evt_errb = eb;
    wr_en = we; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    evt_done = '0; evt_erra = '0; evt_errb = '0; wr_en = 1'b0; wdata = '0;
    for (int c = 0; c < 3; c++) begin
      logic [N-1:0] clr;
      clr = '0;
      if (we && a == 4'(8 + c)) clr = clr | d;
      if (we && a == 4'hC)      clr = clr | d;
      m_raw[c] = (m_raw[c] & ~clr) | ev[c];
      if (we && a == 4'(4 + c)) m_mask[c] = d;
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [N-1:0] v);
    addr = a;
    @(posedge clk);
    @(negedge clk);
    v = rdata;
  endtask

  task automatic check_all();
    logic [N-1:0] v;
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      chk(tag_of(4'(a)), v, exp_read(4'(a)));
    end
    chk("R8 irq level", {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, |m_summary()});
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [N-1:0] v;
    void'($urandom(32'd20250611));
    for (int c = 0; c < 3; c++) begin m_raw[c] = '0; m_mask[c] = '0; end
    chan_busy = 16'hA5C3;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), v);
      chk("R1 reset", v, exp_read(4'(a)));
    end
    chk("R1 irq reset", {{(N-1){1'b0}}, irq}, '0);

    // R2 event sets raw while masked: no irq
    step(16'h0009, 16'h0100, 16'h8000, 1'b0, 4'h0, '0);
    check_all();
    chk("R8 irq masked off", {{(N-1){1'b0}}, irq}, '0);

    // R8 irq timing: enable done mask; irq rises one cycle after summary
    step('0, '0, '0, 1'b1, 4'h4, 16'hFFFF);
    chk("R8 irq one cycle late", {{(N-1){1'b0}}, irq}, '0);
    @(posedge clk); @(negedge clk);
    chk("R8 irq high", {{(N-1){1'b0}}, irq}, 16'h0001);

    // R6 event collides with W1C of the same bit
    step(16'h0008, '0, '0, 1'b1, 4'h8, 16'h0009);
    rd(4'h8, v);
    chk("R6 collision keeps bit", v, 16'h0008);

    // R11 write to read-only address has no effect
    step('0, '0, '0, 1'b1, 4'h0, 16'hFFFF);
    step('0, '0, '0, 1'b1, 4'hB, 16'hFFFF);
    check_all();

    // R9 stop-clear across all classes, plus a collision on error B
    step('0, 16'h0008, 16'h0008, 1'b0, 4'h0, '0);
    step('0, '0, 16'h0008, 1'b1, 4'hC, 16'h8108);
    rd(4'h8, v); chk("R9 stop done", v, m_raw[0]);
    rd(4'h9, v); chk("R9 stop erra", v, 16'h0000);
    rd(4'hA, v); chk("R9 stop errb collision", v, 16'h0008);
    step('0, '0, '0, 1'b1, 4'hC, 16'hFFFF);
    check_all();
    @(posedge clk); @(negedge clk);
    chk("R8 irq low", {{(N-1){1'b0}}, irq}, '0);

    // random phase
    for (int it = 0; it < 80; it++) begin
      logic [3:0] a;
      logic [3:0] wa [8];
      wa = '{4'h4, 4'h5, 4'h6, 4'h8, 4'h9, 4'hA, 4'hC, 4'h0};
      a = wa[$urandom % 8];
      chan_busy = N'($urandom);
      step(N'($urandom & $urandom & $urandom), N'($urandom & $urandom & $urandom),
           N'($urandom & $urandom & $urandom), ($urandom % 4) != 0, a, N'($urandom));
      check_all();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule